// File: doc/BRIEF.md
# Multi-Layer Packet Ejection Multiplexer

This block sits beside the processor of one tile in a stacked multi-layer network. Every layer has a router whose local ejection port delivers packets meant for that tile. The block gives each of these ejection ports its own small flit buffer. It merges the buffered traffic into a single valid/ready flit stream toward the processor. Each delivered flit keeps the virtual-channel tag it arrived with and carries the index of the layer it came from.

Flow control toward the routers is credit based, with a separate credit line for each layer. A layer router starts with as many credits as its buffer has slots. It spends one credit per flit it sends. It gets one back from this block each time a flit leaves that layer's buffer. A round-robin arbiter picks the next layer, but only at a packet boundary. Once a packet begins to appear at the output, its layer keeps the output until the tail flit has been accepted. Packets therefore reach the processor whole and never interleaved.

Top module: `layer_eject_mux`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is low and no `lay_credit` bit is set.
- R2: A flit leaves the output with the same head bit, tail bit, VC tag and data it had at its layer input. `out_layer` gives the index (0 to NUM_LAYERS-1) of the layer it came from.
- R3: Flits from any one layer leave in the order that layer delivered them. No flit is lost and none is repeated.
- R4: After a flit with head=1 and tail=0 is accepted from layer i, every later accepted flit comes from layer i, up to and including the next flit with tail=1.
- R5: At a packet boundary the grant goes to the first layer holding buffered flits, searching upward with wrap-around from the layer after the one whose tail flit was last accepted. After reset the search begins at layer 0.
- R6: Each accepted output flit from layer i sets `lay_credit[i]` for exactly one cycle, in the cycle after the acceptance. At most one credit bit is set in any cycle.
- R7: While `out_valid` is high and `out_ready` is low, the presented flit and its layer index stay unchanged in the next cycle.
- R8: Each layer buffer holds BUF_DEPTH flits. A router that sends only while it holds credits never overflows it, and all credits return once the buffers drain.
- R9: When all layers keep packets waiting and the processor is always ready, the numbers of completed packets per layer never differ by more than one.
- R10: A single-flit packet (head=1 and tail=1) frees the grant at once, so a different layer may be served in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lay_valid | input | NUM_LAYERS | Flit present from each layer router's ejection port |
| lay_head | input | NUM_LAYERS | Head-flit marker per layer |
| lay_tail | input | NUM_LAYERS | Tail-flit marker per layer |
| lay_vc | input | NUM_LAYERS*2 | VC tag per layer, layer i in bits [2i+1:2i] |
| lay_data | input | NUM_LAYERS*32 | Flit payload per layer, layer i in bits [32i+31:32i] |
| lay_credit | output | NUM_LAYERS | One-cycle credit return pulse per layer |
| out_valid | output | 1 | Flit presented to the processor |
| out_ready | input | 1 | Processor accepts the presented flit |
| out_head | output | 1 | Head-flit marker of the presented flit |
| out_tail | output | 1 | Tail-flit marker of the presented flit |
| out_vc | output | 2 | VC tag of the presented flit |
| out_data | output | 32 | Payload of the presented flit |
| out_layer | output | $clog2(NUM_LAYERS) | Source layer of the presented flit |

## Verification
The bench builds the block with its defaults: four layers, five-flit buffers, 32-bit payloads and 2-bit VC tags. Because the buffer depth equals the longest packet, a whole packet can sit in one buffer with the sender's credits at zero. This lets directed cases fill every layer while the processor stalls, then watch the grant rotate and wrap from layer 3 back to layer 0. Random packet lengths from one to five flits, together with random stall patterns, exercise single-flit packets and lock-holding across stalls. A saturated phase with full-length packets checks the fairness bound.

// File: rtl/ejm_pkg.sv
package ejm_pkg;

    localparam int EJ_DATA_W = 32;
    localparam int EJ_VC_W   = 2;

    typedef struct packed {
        logic                 head;
        logic                 tail;
        logic [EJ_VC_W-1:0]   vc;
        logic [EJ_DATA_W-1:0] data;
    } ej_flit_t;

    function automatic ej_flit_t ej_make_flit(input logic head, input logic tail,
                                              input logic [EJ_VC_W-1:0] vc,
                                              input logic [EJ_DATA_W-1:0] data);
        ej_flit_t f;
        f.head = head;
        f.tail = tail;
        f.vc   = vc;
        f.data = data;
        return f;
    endfunction

endpackage

// File: rtl/ejm_flit_buf.sv
module ejm_flit_buf
    import ejm_pkg::*;
#(
    parameter int DEPTH = 5,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  ej_flit_t wr_flit,
    input  logic     rd_en,
    output ej_flit_t rd_flit,
    output logic     not_empty,
    output logic     full
);

    ej_flit_t        slots [DEPTH];
    logic [PW-1:0]   wr_ptr;
    logic [PW-1:0]   rd_ptr;
    logic [CW-1:0]   fill;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_ptr] <= wr_flit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= step(wr_ptr);
            end
            if (rd_en) begin
                rd_ptr <= step(rd_ptr);
            end
            case ({wr_en, rd_en})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign rd_flit   = slots[rd_ptr];
    assign not_empty = (fill != '0);
    assign full      = (fill == CW'(DEPTH));

endmodule

// File: rtl/ejm_pkt_arb.sv
module ejm_pkt_arb #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          take,
    input  logic          last,
    output logic [IW-1:0] sel_idx,
    output logic          sel_valid
);

    logic          locked_q;
    logic [IW-1:0] owner_q;
    logic [IW-1:0] ptr_q;
    logic [IW-1:0] pick;
    logic          found;

    always_comb begin
        pick  = ptr_q;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            logic [IW-1:0] cand;
            cand = IW'((int'(ptr_q) + k) % N);
            if (!found && req[cand]) begin
                pick  = cand;
                found = 1'b1;
            end
        end
    end

    assign sel_idx   = locked_q ? owner_q : pick;
    assign sel_valid = req[sel_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b0;
            owner_q  <= '0;
            ptr_q    <= '0;
        end else if (take && last) begin
            locked_q <= 1'b0;
            ptr_q    <= (sel_idx == IW'(N - 1)) ? '0 : sel_idx + 1'b1;
        end else if (sel_valid) begin
            locked_q <= 1'b1;
            owner_q  <= sel_idx;
        end
    end

endmodule

// File: rtl/ejm_credit_ret.sv
module ejm_credit_ret #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pop,
    output logic [N-1:0] credit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            credit <= '0;
        end else begin
            credit <= pop;
        end
    end

endmodule

// File: rtl/layer_eject_mux.sv
module layer_eject_mux
    import ejm_pkg::*;
#(
    parameter int NUM_LAYERS = 4,
    parameter int BUF_DEPTH  = 5,
    localparam int LAYER_W = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_LAYERS-1:0]           lay_valid,
    input  logic [NUM_LAYERS-1:0]           lay_head,
    input  logic [NUM_LAYERS-1:0]           lay_tail,
    input  logic [NUM_LAYERS*EJ_VC_W-1:0]   lay_vc,
    input  logic [NUM_LAYERS*EJ_DATA_W-1:0] lay_data,
    output logic [NUM_LAYERS-1:0]           lay_credit,
    output logic                            out_valid,
    input  logic                            out_ready,
    output logic                            out_head,
    output logic                            out_tail,
    output logic [EJ_VC_W-1:0]              out_vc,
    output logic [EJ_DATA_W-1:0]            out_data,
    output logic [LAYER_W-1:0]              out_layer
);

    ej_flit_t              buf_head [NUM_LAYERS];
    logic [NUM_LAYERS-1:0] buf_nonempty;
    logic [NUM_LAYERS-1:0] buf_full;
    logic [NUM_LAYERS-1:0] buf_pop;
    logic [LAYER_W-1:0]    sel;
    logic                  sel_valid;
    logic                  accept;
    ej_flit_t              cur;

    for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_layer
        ej_flit_t in_flit;
        assign in_flit = ej_make_flit(lay_head[g], lay_tail[g],
                                      lay_vc[g*EJ_VC_W +: EJ_VC_W],
                                      lay_data[g*EJ_DATA_W +: EJ_DATA_W]);
        assign buf_pop[g] = accept && (sel == LAYER_W'(g));

        ejm_flit_buf #(.DEPTH(BUF_DEPTH)) u_buf (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (lay_valid[g]),
            .wr_flit  (in_flit),
            .rd_en    (buf_pop[g]),
            .rd_flit  (buf_head[g]),
            .not_empty(buf_nonempty[g]),
            .full     (buf_full[g])
        );
    end

    ejm_pkt_arb #(.N(NUM_LAYERS)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .req      (buf_nonempty),
        .take     (accept),
        .last     (cur.tail),
        .sel_idx  (sel),
        .sel_valid(sel_valid)
    );

    assign cur    = buf_head[sel];
    assign accept = sel_valid && out_ready;

    ejm_credit_ret #(.N(NUM_LAYERS)) u_cred (
        .clk   (clk),
        .rst   (rst),
        .pop   (buf_pop),
        .credit(lay_credit)
    );

    assign out_valid = sel_valid;
    assign out_head  = cur.head;
    assign out_tail  = cur.tail;
    assign out_vc    = cur.vc;
    assign out_data  = cur.data;
    assign out_layer = sel;

endmodule

// File: rtl/ejm_checks.sv
module ejm_checks #(
    parameter int NUM_LAYERS = 4,
    parameter int DATA_W     = 32,
    localparam int LAYER_W = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_LAYERS-1:0] lay_valid,
    input logic [NUM_LAYERS-1:0] buf_full,
    input logic [NUM_LAYERS-1:0] lay_credit,
    input logic                  out_valid,
    input logic                  out_ready,
    input logic                  out_tail,
    input logic [DATA_W-1:0]     out_data,
    input logic [LAYER_W-1:0]    out_layer
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) !(|(lay_valid & buf_full))); // R8

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_layer) && $stable(out_tail))); // R7

    AST_PKT_CONTIG: assert property (@(posedge clk) disable iff (rst) (out_valid && out_ready && !out_tail) |=> (!out_valid || out_layer == $past(out_layer))); // R4

    AST_CREDIT_NEXT: assert property (@(posedge clk) disable iff (rst) (out_valid && out_ready) |=> lay_credit[$past(out_layer)]); // R6

    AST_CREDIT_SINGLE: assert property (@(posedge clk) disable iff (rst) $onehot0(lay_credit)); // R6

endmodule

bind layer_eject_mux ejm_checks #(.NUM_LAYERS(NUM_LAYERS), .DATA_W(ejm_pkg::EJ_DATA_W)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .lay_valid (lay_valid),
    .buf_full  (buf_full),
    .lay_credit(lay_credit),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_tail  (out_tail),
    .out_data  (out_data),
    .out_layer (out_layer)
);

// File: tb/tb_layer_eject_mux.sv
module tb_layer_eject_mux;

    localparam int NL    = 4;
    localparam int DEPTH = 5;
    localparam int DW    = 32;
    localparam int VW    = 2;
    localparam int LW    = 2;

    typedef struct packed {
        logic          head;
        logic          tail;
        logic [VW-1:0] vc;
        logic [DW-1:0] data;
    } tflit_t;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NL-1:0]      lay_valid = '0;
    logic [NL-1:0]      lay_head = '0;
    logic [NL-1:0]      lay_tail = '0;
    logic [NL*VW-1:0]   lay_vc = '0;
    logic [NL*DW-1:0]   lay_data = '0;
    logic [NL-1:0]      lay_credit;
    logic               out_valid;
    logic               out_ready = 1'b0;
    logic               out_head;
    logic               out_tail;
    logic [VW-1:0]      out_vc;
    logic [DW-1:0]      out_data;
    logic [LW-1:0]      out_layer;

    always #2.5 clk = ~clk;

    layer_eject_mux #(.NUM_LAYERS(NL), .BUF_DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst),
        .lay_valid(lay_valid), .lay_head(lay_head), .lay_tail(lay_tail),
        .lay_vc(lay_vc), .lay_data(lay_data), .lay_credit(lay_credit),
        .out_valid(out_valid), .out_ready(out_ready), .out_head(out_head),
        .out_tail(out_tail), .out_vc(out_vc), .out_data(out_data),
        .out_layer(out_layer)
    );

    int     total = 0;
    int     bad = 0;
    bit     finished = 0;
    int     cyc = 0;

    tflit_t gen_q [NL][$];
    tflit_t exp_q [NL][$];
    int     up_cred [NL];
    int     seq [NL];
    int     done_cnt [NL];
    int     pkt_order [$];
    logic [NL-1:0] cred_exp = '0;
    bit     hold_chk = 0;
    logic [DW-1:0] hold_data;
    logic [LW-1:0] hold_layer;
    bit     in_pkt = 0;
    int     cur_layer = 0;
    int     rdy_mode = 0;   // 0 low, 1 high, 2 random
    int     send_pct = 100;
    bit     sat_on = 0;
    int     fires = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int spread();
        int mx = done_cnt[0];
        int mn = done_cnt[0];
        for (int i = 1; i < NL; i++) begin
            if (done_cnt[i] > mx) mx = done_cnt[i];
            if (done_cnt[i] < mn) mn = done_cnt[i];
        end
        return mx - mn;
    endfunction

    function automatic bit all_empty();
        for (int i = 0; i < NL; i++) begin
            if (gen_q[i].size() != 0 || exp_q[i].size() != 0) return 0;
        end
        return 1;
    endfunction

    task automatic add_packet(input int layer, input int len, input int vc);
        tflit_t f;
        for (int k = 0; k < len; k++) begin
            f.head = (k == 0);
            f.tail = (k == len - 1);
            f.vc   = VW'(vc);
            f.data = {8'(layer), 24'(seq[layer])};
            seq[layer]++;
            gen_q[layer].push_back(f);
        end
    endtask

    task automatic cycle();
        tflit_t f;
        int bl;
        bit fire;
        @(negedge clk);
        for (int i = 0; i < NL; i++) begin
            if (lay_credit[i] != cred_exp[i])
                chk(0, "R6", "credit pulse timing", lay_credit[i], cred_exp[i]);
            if (lay_credit[i]) up_cred[i]++;
        end
        if (hold_chk) begin
            chk(out_valid && out_data == hold_data && out_layer == hold_layer,
                "R7", "flit held under stall", out_data, hold_data);
        end
        for (int i = 0; i < NL; i++) begin
            if (gen_q[i].size() > 0 && up_cred[i] > 0 && $urandom_range(99) < send_pct) begin
                f = gen_q[i].pop_front();
                lay_valid[i] = 1'b1;
                lay_head[i]  = f.head;
                lay_tail[i]  = f.tail;
                lay_vc[i*VW +: VW] = f.vc;
                lay_data[i*DW +: DW] = f.data;
                exp_q[i].push_back(f);
                up_cred[i]--;
            end else begin
                lay_valid[i] = 1'b0;
            end
        end
        case (rdy_mode)
            0:       out_ready = 1'b0;
            1:       out_ready = 1'b1;
            default: out_ready = ($urandom_range(3) != 0);
        endcase
        fire = out_valid && out_ready;
        hold_chk = out_valid && !out_ready;
        hold_data = out_data;
        hold_layer = out_layer;
        cred_exp = '0;
        if (fire) begin
            fires++;
            bl = int'(out_layer);
            cred_exp[bl] = 1'b1;
            if (exp_q[bl].size() == 0) begin
                chk(0, "R3", "flit with nothing outstanding", bl, -1);
            end else begin
                f = exp_q[bl].pop_front();
                if (out_data != f.data)
                    chk(0, "R3", "per-layer order/data", out_data, f.data);
                if ({out_head, out_tail, out_vc} != {f.head, f.tail, f.vc})
                    chk(0, "R2", "head/tail/vc fields", {out_head, out_tail, out_vc}, {f.head, f.tail, f.vc});
            end
            if (in_pkt) begin
                if (bl != cur_layer) chk(0, "R4", "packet interleaved", bl, cur_layer);
            end else if (!out_head) begin
                chk(0, "R4", "boundary flit not a head", out_head, 1);
            end
            if (out_tail) begin
                in_pkt = 0;
                pkt_order.push_back(bl);
                done_cnt[bl]++;
                if (sat_on) chk(spread() <= 1, "R9", "fairness spread", spread(), 1);
            end else begin
                in_pkt = 1;
                cur_layer = bl;
            end
        end
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) cycle();
    endtask

    task automatic drain(input int limit);
        int k = 0;
        rdy_mode = 1;
        while ((!all_empty() || out_valid) && k < limit) begin
            cycle();
            k++;
        end
        run(3);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int expo [$];
        void'($urandom(32'd1234));
        for (int i = 0; i < NL; i++) begin
            up_cred[i] = DEPTH;
            seq[i] = 0;
            done_cnt[i] = 0;
        end
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        chk(lay_credit == '0, "R1", "credits in reset", lay_credit, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(lay_credit == '0, "R1", "credits after reset", lay_credit, 0);

        // R5: all layers loaded during stall, release, expect rotation from 0
        pkt_order.delete();
        add_packet(3, 2, 1); add_packet(1, 2, 2); add_packet(0, 2, 0); add_packet(2, 2, 3);
        rdy_mode = 0; send_pct = 100;
        run(8);
        chk(out_valid && out_layer == 0 && out_head, "R5", "first grant after reset", out_layer, 0);
        rdy_mode = 1;
        run(8);
        chk(pkt_order.size() == 4, "R5", "packets drained", pkt_order.size(), 4);
        expo = '{0, 1, 2, 3};
        for (int k = 0; k < 4 && k < pkt_order.size(); k++)
            chk(pkt_order[k] == expo[k], "R5", "rotation order", pkt_order[k], expo[k]);
        run(2);

        // R10: single-flit packets free the grant immediately (pointer back at 0)
        pkt_order.delete();
        add_packet(1, 1, 0); add_packet(3, 1, 1); add_packet(1, 1, 2);
        rdy_mode = 0;
        run(6);
        rdy_mode = 1;
        run(3);
        chk(all_empty(), "R10", "three single flits in three cycles", pkt_order.size(), 3);
        expo = '{1, 3, 1};
        for (int k = 0; k < 3 && k < pkt_order.size(); k++)
            chk(pkt_order[k] == expo[k], "R10", "single-flit order", pkt_order[k], expo[k]);
        run(2);

        // R8: fill one buffer to depth with credits exhausted, then drain
        add_packet(2, 5, 1); add_packet(2, 5, 2);
        rdy_mode = 0;
        run(10);
        chk(up_cred[2] == 0, "R8", "credits used up at full buffer", up_cred[2], 0);
        chk(gen_q[2].size() == 5, "R8", "sender waits for credits", gen_q[2].size(), 5);
        drain(200);
        for (int i = 0; i < NL; i++)
            chk(up_cred[i] == DEPTH, "R8", "all credits returned", up_cred[i], DEPTH);

        // R9: saturation with full-length packets
        for (int i = 0; i < NL; i++) done_cnt[i] = 0;
        for (int p = 0; p < 20; p++)
            for (int i = 0; i < NL; i++) add_packet(i, 5, p % 4);
        sat_on = 1;
        rdy_mode = 1; send_pct = 100;
        while (done_cnt[0] + done_cnt[1] + done_cnt[2] + done_cnt[3] < 72) cycle();
        sat_on = 0;
        drain(2000);

        // random phase: random lengths, random stalls and sends
        for (int p = 0; p < 40; p++)
            for (int i = 0; i < NL; i++)
                if ($urandom_range(3) != 0) add_packet(i, 1 + $urandom_range(4), $urandom_range(3));
        rdy_mode = 2; send_pct = 60;
        for (int k = 0; k < 3000 && !all_empty(); k++) cycle();
        send_pct = 100;
        drain(5000);
        chk(all_empty(), "R3", "every flit delivered", 0, 0);
        chk(!out_valid, "R3", "no extra flits", out_valid, 0);
        for (int i = 0; i < NL; i++)
            chk(up_cred[i] == DEPTH, "R6", "credit balance after random run", up_cred[i], DEPTH);
        chk(fires > 300, "R2", "flits moved in total", fires, 300);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule